// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder with Next-PC Selection

This block turns the fields of one 32-bit base-integer instruction into the complete set of datapath controls for a core that fetches, decodes and executes in one clock cycle. It has no state. Each output is a function of the current opcode, funct3 and funct7 fields and, for the next-PC select only, of three comparison flags returned by the ALU.

The decode has two stages. A main decoder groups the opcode into an instruction class. It sets the register and memory write enables, the ALU operand selects, the result source, the immediate format and a PC-update category. An operation decoder picks the ALU operation from funct3 and funct7 and judges whether the function fields are legal for the class. A PC-logic stage combines the category with the flags to produce a 2-bit next-PC select. Bit 1 of that select picks rs1 rather than PC as the adder base. Bit 0 picks the immediate rather than 4 as the offset. The return address for jumps is computed by the ALU itself: it is steered to add PC and the constant 4.

The parameter `STRICT_DECODE` chooses between two variants. When it is 1, function-field combinations that the base set does not define are rejected like unknown opcodes. When it is 0, only the opcode is checked.

Top module: `sc_ctrl_unit`

## Requirements
- R1: Field and encoding conventions. The ALU operation codes are ADD=0, SUB=1, SLL=2, SLT=3, SLTU=4, XOR=5, SRL=6, SRA=7, OR=8 and AND=9. The operand-A select uses 00 for rs1, 01 for zero and 11 for PC. The operand-B select uses 00 for rs2, 01 for the constant 4 and 10 for the immediate. The immediate format uses I=0, S=1, B=2, U=3 and J=4. `result_sel` is 1 for memory data and 0 for the ALU result.
- R2: Register-register operations (opcode 0110011) set `reg_wr`=1 and both operand selects to 00. The operation comes from funct3; funct7=0100000 turns funct3 000 into SUB and funct3 101 into SRA.
- R3: Register-immediate operations (opcode 0010011) set `reg_wr`=1, operand B to the immediate and the format to I. funct3 000 is always ADD, whatever the upper bits hold. funct3 101 with funct7=0100000 gives SRA.
- R4: A load (opcode 0000011) sets `reg_wr`=1, operand B to the immediate, format I, ADD and `result_sel`=1. A store (opcode 0100011) sets `mem_wr`=1 and `reg_wr`=0, operand B to the immediate, format S and ADD.
- R5: A conditional branch (opcode 1100011) writes nothing. It sets both operand selects to 00, SUB, format B and category `pcs`=01.
- R6: The branch condition comes from funct3 and the flags `alu_flags`={eq,lt,ltu}, with eq in bit 2. 000 takes the branch on eq, 001 on not eq, 100 on lt, 101 on not lt, 110 on ltu and 111 on not ltu. A taken branch gives `pc_sel`=01; a branch that is not taken gives 00.
- R7: jal (opcode 1101111) sets `reg_wr`=1, operand A to 11, operand B to 01, ADD, format J, `pcs`=10 and `pc_sel`=01, whatever the flags.
- R8: jalr (opcode 1100111, funct3 000) sets `reg_wr`=1, operand A to 11, operand B to 01, ADD, format I, `pcs`=11 and `pc_sel`=11, whatever the flags.
- R9: lui (opcode 0110111) sets operand A to 01. auipc (opcode 0010111) sets operand A to 11. Both set `reg_wr`=1, operand B to the immediate, format U and ADD.
- R10: An unrecognized opcode drives every output to zero: no write, category 00 and `pc_sel`=00, whatever the flags.
- R11: With `STRICT_DECODE`=1, an undefined function-field combination drives every output to zero. The cases are an R-type funct7 other than 0000000 or 0100000 (SUB and SRA only), a shift-immediate funct7 outside its allowed values, load funct3 011/110/111, store funct3 above 010, branch funct3 010/011, and jalr funct3 other than 000. With 0, such instructions decode by their opcode alone, and a branch with funct3 010/011 is never taken.
- R12: `reg_wr` and `mem_wr` are never high together, so each instruction updates at most one architectural location.
- R13: For every category other than branch, `pc_sel` does not depend on `alu_flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 7 | Instruction bits 6:0 |
| funct3 | input | 3 | Instruction bits 14:12 |
| funct7 | input | 7 | Instruction bits 31:25 |
| alu_flags | input | 3 | ALU comparison flags {eq, lt, ltu} |
| reg_wr | output | 1 | Register file write enable |
| mem_wr | output | 1 | Data memory write enable |
| src_a_sel | output | 2 | ALU operand A select |
| src_b_sel | output | 2 | ALU operand B select |
| alu_op | output | 4 | ALU operation code |
| result_sel | output | 1 | Write-back source (1 = memory) |
| imm_kind | output | 3 | Immediate format |
| pcs | output | 2 | PC-update category (00 none, 01 branch, 10 jal, 11 jalr) |
| pc_sel | output | 2 | Next-PC select: bit 1 base rs1, bit 0 offset immediate |

## Verification
The bench builds two copies side by side: `u_dut` with `STRICT_DECODE`=1 and `u_dut_loose` with 0. Both copies receive the same undefined function-field encodings. This shows in one run that the strict copy squashes them to the all-zero outputs while the loose copy still decodes by opcode. Every branch condition is driven with both flag polarities. Jumps and unknown opcodes are driven with all flags set, to show that the flags cannot move their next-PC select.

// File: rtl/sc_ctrl_pkg.sv
// Shared widths, encodings and types for the single-cycle control decoder.
// Assumes base 32-bit integer instruction field layout.
package sc_ctrl_pkg;

    localparam int OPC_W   = 7;
    localparam int F3_W    = 3;
    localparam int F7_W    = 7;
    localparam int FLAG_W  = 3;
    localparam int ALUOP_W = 4;
    localparam int SEL_W   = 2;
    localparam int IMM_W   = 3;

    // flag bit positions inside alu_flags
    localparam int FL_EQ  = 2;
    localparam int FL_LT  = 1;
    localparam int FL_LTU = 0;

    localparam logic [OPC_W-1:0] OPC_REG    = 7'b0110011;
    localparam logic [OPC_W-1:0] OPC_IMM    = 7'b0010011;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
    localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
    localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
    localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;
    localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
    localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'b0010111;

    localparam logic [F7_W-1:0] F7_BASE = 7'b0000000;
    localparam logic [F7_W-1:0] F7_ALT  = 7'b0100000;

    typedef enum logic [3:0] {
        CL_NONE, CL_REG, CL_IMM, CL_LOAD, CL_STORE,
        CL_BRANCH, CL_JAL, CL_JALR, CL_LUI, CL_AUIPC
    } instr_class_e;

    typedef enum logic [ALUOP_W-1:0] {
        OP_ADD = 4'd0, OP_SUB = 4'd1, OP_SLL = 4'd2, OP_SLT = 4'd3,
        OP_SLTU = 4'd4, OP_XOR = 4'd5, OP_SRL = 4'd6, OP_SRA = 4'd7,
        OP_OR = 4'd8, OP_AND = 4'd9
    } alu_op_e;

    typedef enum logic [SEL_W-1:0] {
        SA_RS1 = 2'b00, SA_ZERO = 2'b01, SA_PC = 2'b11
    } src_a_e;

    typedef enum logic [SEL_W-1:0] {
        SB_RS2 = 2'b00, SB_FOUR = 2'b01, SB_IMM = 2'b10
    } src_b_e;

    typedef enum logic [IMM_W-1:0] {
        IMM_I = 3'd0, IMM_S = 3'd1, IMM_B = 3'd2, IMM_U = 3'd3, IMM_J = 3'd4
    } imm_kind_e;

    typedef enum logic [SEL_W-1:0] {
        PCS_NONE = 2'b00, PCS_BRANCH = 2'b01, PCS_JAL = 2'b10, PCS_JALR = 2'b11
    } pcs_e;

    // How the operation decoder picks the ALU operation
    typedef enum logic [1:0] {
        AM_ADD, AM_SUB, AM_REG, AM_IMM
    } alu_mode_e;

    typedef struct packed {
        logic      reg_wr;
        logic      mem_wr;
        src_a_e    src_a;
        src_b_e    src_b;
        logic      result_mem;
        imm_kind_e imm;
        pcs_e      pcs;
        alu_mode_e alu_mode;
    } ctrl_raw_t;

endpackage

// File: rtl/sc_main_dec.sv
// Main decoder: classifies the opcode and produces the raw datapath controls.
// Assumes a purely combinational single-cycle datapath; function fields are
// judged elsewhere, so these controls may still be squashed downstream.
module sc_main_dec
    import sc_ctrl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output instr_class_e     iclass,
    output ctrl_raw_t        raw
);

    // Map opcode to class and default controls for that class
    always_comb begin
        iclass         = CL_NONE;
        raw.reg_wr     = 1'b0;
        raw.mem_wr     = 1'b0;
        raw.src_a      = SA_RS1;
        raw.src_b      = SB_RS2;
        raw.result_mem = 1'b0;
        raw.imm        = IMM_I;
        raw.pcs        = PCS_NONE;
        raw.alu_mode   = AM_ADD;
        unique case (opcode)
            OPC_REG: begin
                iclass       = CL_REG;
                raw.reg_wr   = 1'b1;
                raw.alu_mode = AM_REG;
            end
            OPC_IMM: begin
                iclass       = CL_IMM;
                raw.reg_wr   = 1'b1;
                raw.src_b    = SB_IMM;
                raw.alu_mode = AM_IMM;
            end
            OPC_LOAD: begin
                iclass         = CL_LOAD;
                raw.reg_wr     = 1'b1;
                raw.src_b      = SB_IMM;
                raw.result_mem = 1'b1;
            end
            OPC_STORE: begin
                iclass     = CL_STORE;
                raw.mem_wr = 1'b1;
                raw.src_b  = SB_IMM;
                raw.imm    = IMM_S;
            end
            OPC_BRANCH: begin
                iclass       = CL_BRANCH;
                raw.imm      = IMM_B;
                raw.pcs      = PCS_BRANCH;
                raw.alu_mode = AM_SUB;
            end
            OPC_JAL: begin
                iclass     = CL_JAL;
                raw.reg_wr = 1'b1;
                raw.src_a  = SA_PC;
                raw.src_b  = SB_FOUR;
                raw.imm    = IMM_J;
                raw.pcs    = PCS_JAL;
            end
            OPC_JALR: begin
                iclass     = CL_JALR;
                raw.reg_wr = 1'b1;
                raw.src_a  = SA_PC;
                raw.src_b  = SB_FOUR;
                raw.pcs    = PCS_JALR;
            end
            OPC_LUI: begin
                iclass     = CL_LUI;
                raw.reg_wr = 1'b1;
                raw.src_a  = SA_ZERO;
                raw.src_b  = SB_IMM;
                raw.imm    = IMM_U;
            end
            OPC_AUIPC: begin
                iclass     = CL_AUIPC;
                raw.reg_wr = 1'b1;
                raw.src_a  = SA_PC;
                raw.src_b  = SB_IMM;
                raw.imm    = IMM_U;
            end
            default: iclass = CL_NONE;
        endcase

        // A jump must compute its link value as PC + 4
        AST_LINK_PC_PLUS4: assert (!(raw.pcs == PCS_JAL || raw.pcs == PCS_JALR)
                                   || (raw.src_a == SA_PC && raw.src_b == SB_FOUR))
            else $error("jump without PC+4 link operands"); // R7
        // Unknown opcodes carry no write and no PC change
        AST_NONE_QUIET: assert (iclass != CL_NONE
                                || (!raw.reg_wr && !raw.mem_wr && raw.pcs == PCS_NONE))
            else $error("unknown opcode has side effects"); // R10
    end

endmodule

// File: rtl/sc_op_dec.sv
// Operation decoder: picks the ALU operation from funct3/funct7 and judges
// whether the function fields are defined for the instruction class.
// STRICT selects full field checking; otherwise only the class must be known.
module sc_op_dec
    import sc_ctrl_pkg::*;
#(
    parameter bit STRICT = 1'b1
)(
    input  instr_class_e    iclass,
    input  alu_mode_e       alu_mode,
    input  logic [F3_W-1:0] funct3,
    input  logic [F7_W-1:0] funct7,
    output alu_op_e         alu_op,
    output logic            funct_ok
);

    localparam int ALT_BIT = 5;

    logic strict_ok;

    // Translate funct3 plus the alternate bit into an operation
    always_comb begin
        alu_op = OP_ADD;
        unique case (alu_mode)
            AM_ADD: alu_op = OP_ADD;
            AM_SUB: alu_op = OP_SUB;
            AM_REG, AM_IMM: begin
                unique case (funct3)
                    3'b000: alu_op = (alu_mode == AM_REG && funct7[ALT_BIT]) ? OP_SUB : OP_ADD;
                    3'b001: alu_op = OP_SLL;
                    3'b010: alu_op = OP_SLT;
                    3'b011: alu_op = OP_SLTU;
                    3'b100: alu_op = OP_XOR;
                    3'b101: alu_op = funct7[ALT_BIT] ? OP_SRA : OP_SRL;
                    3'b110: alu_op = OP_OR;
                    default: alu_op = OP_AND;
                endcase
            end
            default: alu_op = OP_ADD;
        endcase
    end

    // Judge function-field legality per class under full checking
    always_comb begin
        strict_ok = 1'b0;
        unique case (iclass)
            CL_REG: begin
                if (funct7 == F7_BASE)
                    strict_ok = 1'b1;
                else if (funct7 == F7_ALT)
                    strict_ok = (funct3 == 3'b000) || (funct3 == 3'b101);
            end
            CL_IMM: begin
                if (funct3 == 3'b001)
                    strict_ok = (funct7 == F7_BASE);
                else if (funct3 == 3'b101)
                    strict_ok = (funct7 == F7_BASE) || (funct7 == F7_ALT);
                else
                    strict_ok = 1'b1;
            end
            CL_LOAD:   strict_ok = (funct3 != 3'b011) && (funct3 != 3'b110) && (funct3 != 3'b111);
            CL_STORE:  strict_ok = (funct3 <= 3'b010);
            CL_BRANCH: strict_ok = (funct3 != 3'b010) && (funct3 != 3'b011);
            CL_JALR:   strict_ok = (funct3 == 3'b000);
            CL_JAL, CL_LUI, CL_AUIPC: strict_ok = 1'b1;
            default:   strict_ok = 1'b0;
        endcase
    end

    // Variant choice made at elaboration
    generate
        if (STRICT) begin : g_strict
            assign funct_ok = strict_ok;
        end else begin : g_loose
            assign funct_ok = (iclass != CL_NONE) || strict_ok;
        end
    endgenerate

endmodule

// File: rtl/sc_pc_logic.sv
// PC logic: turns the PC-update category, the branch condition (funct3) and
// the ALU flags {eq, lt, ltu} into the 2-bit next-PC select.
// Bit 1 = base rs1 instead of PC, bit 0 = offset immediate instead of 4.
module sc_pc_logic
    import sc_ctrl_pkg::*;
(
    input  pcs_e              pcs,
    input  logic [F3_W-1:0]   cond,
    input  logic [FLAG_W-1:0] alu_flags,
    output logic [SEL_W-1:0]  pc_sel
);

    logic taken;

    // Evaluate the branch condition against the flags
    always_comb begin
        unique case (cond)
            3'b000:  taken =  alu_flags[FL_EQ];
            3'b001:  taken = !alu_flags[FL_EQ];
            3'b100:  taken =  alu_flags[FL_LT];
            3'b101:  taken = !alu_flags[FL_LT];
            3'b110:  taken =  alu_flags[FL_LTU];
            3'b111:  taken = !alu_flags[FL_LTU];
            default: taken = 1'b0;
        endcase
    end

    // Choose the next-PC base and offset
    always_comb begin
        unique case (pcs)
            PCS_BRANCH: pc_sel = taken ? 2'b01 : 2'b00;
            PCS_JAL:    pc_sel = 2'b01;
            PCS_JALR:   pc_sel = 2'b11;
            default:    pc_sel = 2'b00;
        endcase

        AST_SEQ_WHEN_IDLE: assert (pcs != PCS_NONE || pc_sel == 2'b00)
            else $error("next-PC moved without a category"); // R10
        AST_RS1_BASE_JALR: assert (!pc_sel[1] || pcs == PCS_JALR)
            else $error("rs1 base chosen outside jalr"); // R8
        AST_JUMP_ALWAYS: assert (pcs != PCS_JAL || pc_sel == 2'b01)
            else $error("jal did not redirect"); // R7
    end

endmodule

// File: rtl/sc_ctrl_unit.sv
// Single-cycle control decoder top: main decoder, operation decoder, a squash
// stage for undefined encodings, and the PC logic. No state, no clock.
module sc_ctrl_unit
    import sc_ctrl_pkg::*;
#(
    parameter bit STRICT_DECODE = 1'b1
)(
    input  logic [OPC_W-1:0]   opcode,
    input  logic [F3_W-1:0]    funct3,
    input  logic [F7_W-1:0]    funct7,
    input  logic [FLAG_W-1:0]  alu_flags,
    output logic               reg_wr,
    output logic               mem_wr,
    output logic [SEL_W-1:0]   src_a_sel,
    output logic [SEL_W-1:0]   src_b_sel,
    output logic [ALUOP_W-1:0] alu_op,
    output logic               result_sel,
    output logic [IMM_W-1:0]   imm_kind,
    output logic [SEL_W-1:0]   pcs,
    output logic [SEL_W-1:0]   pc_sel
);

    instr_class_e iclass;
    ctrl_raw_t    raw;
    alu_op_e      op_raw;
    logic         funct_ok;
    pcs_e         pcs_q;

    sc_main_dec u_main (
        .opcode (opcode),
        .iclass (iclass),
        .raw    (raw)
    );

    sc_op_dec #(.STRICT(STRICT_DECODE)) u_op (
        .iclass   (iclass),
        .alu_mode (raw.alu_mode),
        .funct3   (funct3),
        .funct7   (funct7),
        .alu_op   (op_raw),
        .funct_ok (funct_ok)
    );

    // Squash every control of an undefined encoding to the idle value
    always_comb begin
        reg_wr     = funct_ok & raw.reg_wr;
        mem_wr     = funct_ok & raw.mem_wr;
        src_a_sel  = funct_ok ? raw.src_a : SA_RS1;
        src_b_sel  = funct_ok ? raw.src_b : SB_RS2;
        alu_op     = funct_ok ? op_raw : OP_ADD;
        result_sel = funct_ok & raw.result_mem;
        imm_kind   = funct_ok ? raw.imm : IMM_I;
        pcs_q      = funct_ok ? raw.pcs : PCS_NONE;
        pcs        = pcs_q;

        AST_ONE_WRITER: assert (!(reg_wr && mem_wr))
            else $error("two architectural writes"); // R12
    end

    sc_pc_logic u_pc (
        .pcs       (pcs_q),
        .cond      (funct3),
        .alu_flags (alu_flags),
        .pc_sel    (pc_sel)
    );

endmodule

// File: tb/sc_ctrl_unit_tb.sv
module sc_ctrl_unit_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [6:0] opcode = '0;
    logic [2:0] funct3 = '0;
    logic [6:0] funct7 = '0;
    logic [2:0] flags  = '0;

    logic s_rw, s_mw, s_res, l_rw, l_mw, l_res;
    logic [1:0] s_a, s_b, s_pcs, s_sel, l_a, l_b, l_pcs, l_sel;
    logic [3:0] s_op, l_op;
    logic [2:0] s_imm, l_imm;

    int total = 0;
    int bad = 0;

    sc_ctrl_unit #(.STRICT_DECODE(1'b1)) u_dut (
        .opcode(opcode), .funct3(funct3), .funct7(funct7), .alu_flags(flags),
        .reg_wr(s_rw), .mem_wr(s_mw), .src_a_sel(s_a), .src_b_sel(s_b),
        .alu_op(s_op), .result_sel(s_res), .imm_kind(s_imm), .pcs(s_pcs), .pc_sel(s_sel)
    );

    sc_ctrl_unit #(.STRICT_DECODE(1'b0)) u_dut_loose (
        .opcode(opcode), .funct3(funct3), .funct7(funct7), .alu_flags(flags),
        .reg_wr(l_rw), .mem_wr(l_mw), .src_a_sel(l_a), .src_b_sel(l_b),
        .alu_op(l_op), .result_sel(l_res), .imm_kind(l_imm), .pcs(l_pcs), .pc_sel(l_sel)
    );

    wire [17:0] strict_v = {s_rw, s_mw, s_a, s_b, s_op, s_res, s_imm, s_pcs, s_sel};
    wire [17:0] loose_v  = {l_rw, l_mw, l_a, l_b, l_op, l_res, l_imm, l_pcs, l_sel};

    // Pack an expected control vector
    function automatic logic [17:0] ev(bit rw, bit mw, bit [1:0] a, bit [1:0] b,
                                       bit [3:0] op, bit res, bit [2:0] imm,
                                       bit [1:0] pc_cat, bit [1:0] sel);
        return {rw, mw, a, b, op, res, imm, pc_cat, sel};
    endfunction

    localparam logic [17:0] IDLE = 18'd0;

    // Drive one encoding between edges, then compare both copies
    task automatic drive(input logic [6:0] o, input logic [2:0] f3,
                         input logic [6:0] f7, input logic [2:0] fl);
        @(negedge clk);
        opcode = o; funct3 = f3; funct7 = f7; flags = fl;
        #2;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [17:0] act, input logic [17:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic t_reset_state;
        drive(7'd0, 3'd0, 7'd0, 3'b000);
        chk("R10", "opcode 0 after reset", strict_v, IDLE);
        chk("R10", "opcode 0 loose", loose_v, IDLE);
    endtask

    task automatic t_reg_ops;
        drive(7'b0110011, 3'b000, 7'b0000000, 3'b000);
        chk("R2", "add", strict_v, ev(1,0,2'b00,2'b00,4'd0,0,3'd0,2'b00,2'b00));
        drive(7'b0110011, 3'b000, 7'b0100000, 3'b000);
        chk("R2", "sub", strict_v, ev(1,0,2'b00,2'b00,4'd1,0,3'd0,2'b00,2'b00));
        drive(7'b0110011, 3'b101, 7'b0100000, 3'b000);
        chk("R2", "sra", strict_v, ev(1,0,2'b00,2'b00,4'd7,0,3'd0,2'b00,2'b00));
        drive(7'b0110011, 3'b011, 7'b0000000, 3'b000);
        chk("R1", "sltu code", strict_v, ev(1,0,2'b00,2'b00,4'd4,0,3'd0,2'b00,2'b00));
        drive(7'b0110011, 3'b111, 7'b0000000, 3'b000);
        chk("R1", "and code", strict_v, ev(1,0,2'b00,2'b00,4'd9,0,3'd0,2'b00,2'b00));
    endtask

    task automatic t_imm_ops;
        drive(7'b0010011, 3'b000, 7'b0100000, 3'b000);
        chk("R3", "addi with upper bits set", strict_v, ev(1,0,2'b00,2'b10,4'd0,0,3'd0,2'b00,2'b00));
        drive(7'b0010011, 3'b101, 7'b0100000, 3'b000);
        chk("R3", "srai", strict_v, ev(1,0,2'b00,2'b10,4'd7,0,3'd0,2'b00,2'b00));
        drive(7'b0010011, 3'b001, 7'b0000000, 3'b000);
        chk("R3", "slli", strict_v, ev(1,0,2'b00,2'b10,4'd2,0,3'd0,2'b00,2'b00));
    endtask

    task automatic t_mem_ops;
        drive(7'b0000011, 3'b010, 7'b1010101, 3'b000);
        chk("R4", "lw", strict_v, ev(1,0,2'b00,2'b10,4'd0,1,3'd0,2'b00,2'b00));
        drive(7'b0100011, 3'b010, 7'b0000000, 3'b000);
        chk("R4", "sw", strict_v, ev(0,1,2'b00,2'b10,4'd0,0,3'd1,2'b00,2'b00));
        chk("R12", "store single writer", {16'd0, strict_v[17], strict_v[16]}, {16'd0, 2'b01});
    endtask

    task automatic t_branches;
        logic [17:0] nt;
        logic [17:0] tk;
        nt = ev(0,0,2'b00,2'b00,4'd1,0,3'd2,2'b01,2'b00);
        tk = ev(0,0,2'b00,2'b00,4'd1,0,3'd2,2'b01,2'b01);
        drive(7'b1100011, 3'b000, 7'd0, 3'b100); chk("R6", "beq eq=1", strict_v, tk);
        drive(7'b1100011, 3'b000, 7'd0, 3'b011); chk("R5", "beq eq=0", strict_v, nt);
        drive(7'b1100011, 3'b001, 7'd0, 3'b000); chk("R6", "bne eq=0", strict_v, tk);
        drive(7'b1100011, 3'b001, 7'd0, 3'b100); chk("R6", "bne eq=1", strict_v, nt);
        drive(7'b1100011, 3'b100, 7'd0, 3'b010); chk("R6", "blt lt=1", strict_v, tk);
        drive(7'b1100011, 3'b100, 7'd0, 3'b101); chk("R6", "blt lt=0", strict_v, nt);
        drive(7'b1100011, 3'b101, 7'd0, 3'b010); chk("R6", "bge lt=1", strict_v, nt);
        drive(7'b1100011, 3'b101, 7'd0, 3'b000); chk("R6", "bge lt=0", strict_v, tk);
        drive(7'b1100011, 3'b110, 7'd0, 3'b001); chk("R6", "bltu ltu=1", strict_v, tk);
        drive(7'b1100011, 3'b110, 7'd0, 3'b110); chk("R6", "bltu ltu=0", strict_v, nt);
        drive(7'b1100011, 3'b111, 7'd0, 3'b001); chk("R6", "bgeu ltu=1", strict_v, nt);
        drive(7'b1100011, 3'b111, 7'd0, 3'b000); chk("R6", "bgeu ltu=0", strict_v, tk);
    endtask

    task automatic t_jumps;
        for (int f = 0; f < 8; f += 7) begin
            drive(7'b1101111, 3'b011, 7'd0, f[2:0]);
            chk("R7", "jal", strict_v, ev(1,0,2'b11,2'b01,4'd0,0,3'd4,2'b10,2'b01));
            chk("R13", "jal flags ignored", {16'd0, strict_v[1:0]}, {16'd0, 2'b01});
            drive(7'b1100111, 3'b000, 7'd0, f[2:0]);
            chk("R8", "jalr", strict_v, ev(1,0,2'b11,2'b01,4'd0,0,3'd0,2'b11,2'b11));
        end
    endtask

    task automatic t_upper;
        drive(7'b0110111, 3'b101, 7'b1111111, 3'b111);
        chk("R9", "lui", strict_v, ev(1,0,2'b01,2'b10,4'd0,0,3'd3,2'b00,2'b00));
        drive(7'b0010111, 3'b000, 7'b0000000, 3'b000);
        chk("R9", "auipc", strict_v, ev(1,0,2'b11,2'b10,4'd0,0,3'd3,2'b00,2'b00));
        chk("R13", "auipc flags ignored (all set next)", {16'd0, strict_v[1:0]}, 18'd0);
        drive(7'b0010111, 3'b000, 7'b0000000, 3'b111);
        chk("R13", "auipc flags all set", {16'd0, strict_v[1:0]}, 18'd0);
    endtask

    task automatic t_unknown;
        drive(7'b1111111, 3'b000, 7'd0, 3'b111);
        chk("R10", "unknown opcode", strict_v, IDLE);
        chk("R10", "unknown opcode loose", loose_v, IDLE);
        drive(7'b0001111, 3'b001, 7'd0, 3'b100);
        chk("R10", "fence-like opcode", strict_v, IDLE);
    endtask

    task automatic t_strict_vs_loose;
        drive(7'b0110011, 3'b000, 7'b0000001, 3'b000);
        chk("R11", "mul strict", strict_v, IDLE);
        chk("R11", "mul loose", loose_v, ev(1,0,2'b00,2'b00,4'd0,0,3'd0,2'b00,2'b00));
        drive(7'b0110011, 3'b100, 7'b0100000, 3'b000);
        chk("R11", "xor alt strict", strict_v, IDLE);
        drive(7'b0010011, 3'b001, 7'b0100000, 3'b000);
        chk("R11", "slli alt strict", strict_v, IDLE);
        drive(7'b0000011, 3'b011, 7'd0, 3'b000);
        chk("R11", "load f3=011 strict", strict_v, IDLE);
        chk("R11", "load f3=011 loose", loose_v, ev(1,0,2'b00,2'b10,4'd0,1,3'd0,2'b00,2'b00));
        drive(7'b0100011, 3'b100, 7'd0, 3'b000);
        chk("R11", "store f3=100 strict", strict_v, IDLE);
        drive(7'b1100011, 3'b010, 7'd0, 3'b111);
        chk("R11", "branch f3=010 strict", strict_v, IDLE);
        chk("R11", "branch f3=010 loose", loose_v, ev(0,0,2'b00,2'b00,4'd1,0,3'd2,2'b01,2'b00));
        drive(7'b1100111, 3'b001, 7'd0, 3'b111);
        chk("R11", "jalr f3=001 strict", strict_v, IDLE);
        chk("R11", "jalr f3=001 loose", loose_v, ev(1,0,2'b11,2'b01,4'd0,0,3'd0,2'b11,2'b11));
    endtask

    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        t_reset_state();
        rst_n = 1'b1;
        t_reg_ops();
        t_imm_ops();
        t_mem_ops();
        t_branches();
        t_jumps();
        t_upper();
        t_unknown();
        t_strict_vs_loose();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule